// File: doc/BRIEF.md
# NAND Host Bus Cycle Sequencer

This block runs the host end of an 8-bit multiplexed NAND bus. A single request describes one complete transfer. The transfer is a first opcode, an optional address phase, an optional stream of bytes to write, an optional confirm opcode, an optional wait on the ready/busy line, and an optional number of bytes to read back. The sequencer turns that request into chip-select, command-latch, address-latch, write-strobe and read-strobe waveforms. Every phase is a whole number of system-clock cycles, and each phase length is set by a parameter.

Write bytes arrive on a valid/ready stream and go out one per write strobe. Read bytes are captured at the end of each read-strobe low phase. They are handed back one per valid/ready handshake, and no new read strobe is issued until the previous byte has been taken. The ready/busy input passes through a two-flop synchronizer before the sequencer uses it. If the device stays busy longer than a set number of cycles, the sequencer ends the transfer and raises an error flag.

Top module: `nand_bus_sequencer`

## Requirements
- R1: After reset and whenever no transfer is running, `req_ready` is high, chip select (`nand_ce_n`) is high, both strobes are high and both latch enables are low. While a transfer runs, `req_ready` is low.
- R2: A command cycle drives the opcode on `nand_dq_out` with `nand_cle` high and `nand_ale` low. The byte is taken at the write-strobe rising edge. The first opcode (`req_cmd1`) comes before any other cycle, and the confirm opcode (`req_cmd2`, sent only when `req_has_cmd2` is 1) comes after any write data.
- R3: `req_addr_mode` selects the address cycles, each sent with `nand_ale` high. The modes are: 0 = none; 1 = one cycle carrying `req_addr[7:0]`; 2 = two cycles carrying `req_addr[19:12]` then `req_addr[27:20]`; 3 = four cycles carrying `req_addr[7:0]`, then `{4'b0, req_addr[11:8]}`, then `req_addr[19:12]`, then `req_addr[27:20]`.
- R4: The first data write-strobe rising edge comes at least `T_ADL` cycles after the rising edge of the last address cycle.
- R5: `req_wr_len` bytes are taken from the write stream, one per `wr_valid`/`wr_ready` handshake. They are sent in order, one per write-strobe with both latch enables low.
- R6: When `req_wait_busy` is 1, the transfer does not read and does not finish until the ready/busy input has gone low and then returned high.
- R7: After a busy wait, the first read-strobe falling edge comes at least `T_RR` cycles after the ready/busy input rises.
- R8: Without a busy wait, the first read-strobe falling edge comes at least `T_WHR` cycles after the last write-strobe rising edge.
- R9: `req_rd_len` read strobes are issued. Each captured byte is offered on `rd_data` with `rd_valid` and held until `rd_ready`. The read strobe stays high while a byte is waiting, and bytes return in column order.
- R10: If the ready/busy input stays low longer than `BUSY_LIMIT` cycles of waiting, `busy_err` goes high and the transfer ends with `op_done`. `busy_err` clears when the next request is accepted.
- R11: `nand_cle` and `nand_ale` are never high together, the two strobes are never low together, and no strobe goes low while chip select is high.
- R12: `op_done` is a one-cycle pulse at the end of every transfer, after which `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when both high |
| req_cmd1 | input | 8 | First opcode |
| req_cmd2 | input | 8 | Confirm opcode |
| req_has_cmd2 | input | 1 | Send the confirm opcode |
| req_addr_mode | input | 2 | Address cycle selection (see R3) |
| req_addr | input | 28 | Column in bits 11:0, row in bits 27:12 |
| req_wait_busy | input | 1 | Wait for ready/busy after the command phase |
| req_wr_len | input | LEN_W | Bytes to write |
| req_rd_len | input | LEN_W | Bytes to read |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte offered |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| op_done | output | 1 | End-of-transfer pulse |
| busy_err | output | 1 | Busy wait timed out |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus driver enable |
| nand_dq_in | input | 8 | Bus byte from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low when busy |

## Verification
A wrong phase state shows up on the latch enables or strobes within one cycle. Examples are an address cycle sent with the command latch enable, or a read strobe overlapping a write strobe. A wrong byte index or remaining-count shows at the next write-strobe rising edge as a misordered or extra address or data byte. A miscounted gap shows as a gap between two strobe edges that is shorter than its parameter. A fault in the busy wait shows either as an early read strobe or `op_done` before ready/busy rises, or as a transfer that never ends. A fault in the read handshake shows as a read strobe issued while `rd_valid` is still high.

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer #(
  parameter int T_WL       = 1,
  parameter int T_WH       = 1,
  parameter int T_RL       = 1,
  parameter int T_RH       = 1,
  parameter int T_ADL      = 5,
  parameter int T_WHR      = 3,
  parameter int T_RR       = 1,
  parameter int T_WB       = 5,
  parameter int BUSY_LIMIT = 1000,
  parameter int LEN_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd1,
  input  logic [7:0]       req_cmd2,
  input  logic             req_has_cmd2,
  input  logic [1:0]       req_addr_mode,
  input  logic [27:0]      req_addr,
  input  logic             req_wait_busy,
  input  logic [LEN_W-1:0] req_wr_len,
  input  logic [LEN_W-1:0] req_rd_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             op_done,
  output logic             busy_err,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb_n
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ADL_N = mx(1, T_ADL - T_WH - T_WL);
  localparam int WHR_N = mx(1, T_WHR - T_WH);
  localparam int WB_N  = T_WB + 2;
  localparam int RR_N  = mx(1, T_RR);
  localparam int MAX_T = mx(mx(mx(T_WL, T_WH), mx(T_RL, T_RH)), mx(mx(ADL_N, WHR_N), mx(WB_N, RR_N)));
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int BSY_W = $clog2(BUSY_LIMIT + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_C1L, S_C1H, S_AL, S_AH, S_ADL, S_WW, S_WL, S_WH,
    S_C2L, S_C2H, S_WB, S_BSY, S_RR, S_WHR, S_RL, S_RH, S_DONE
  } st_t;

  st_t              state, nxt;
  logic             go, leave;
  logic [CNT_W-1:0] cnt;
  logic [BSY_W-1:0] bcnt;
  logic [7:0]       cmd1_q, cmd2_q, wbyte_q, abyte;
  logic             has2_q, wb_q, err_q, rb_s1, rb_s2;
  logic [27:0]      addr_q;
  logic [1:0]       adr_idx;
  logic [2:0]       adr_left;
  logic [LEN_W-1:0] wr_left, rd_left;

  function automatic st_t stage_from(input int s);
    if (s <= 1 && adr_left != 3'd0)     return S_AL;
    if (s <= 2 && wr_left != '0)        return S_WW;
    if (s <= 3 && has2_q)               return S_C2L;
    if (s <= 4 && wb_q)                 return S_WB;
    if (s <= 5 && rd_left != '0)        return S_WHR;
    return S_DONE;
  endfunction

  function automatic int len_of(input st_t s);
    case (s)
      S_C1L, S_AL, S_WL, S_C2L: return T_WL;
      S_C1H, S_AH, S_WH, S_C2H: return T_WH;
      S_ADL:                    return ADL_N;
      S_WHR:                    return WHR_N;
      S_WB:                     return WB_N;
      S_RR:                     return RR_N;
      S_RL:                     return T_RL;
      S_RH:                     return T_RH;
      default:                  return 1;
    endcase
  endfunction

  assign leave = (cnt == '0);

  always_comb begin
    nxt = state;
    go  = 1'b0;
    case (state)
      S_IDLE: if (req_valid) begin nxt = S_C1L; go = 1'b1; end
      S_C1L:  if (leave) begin nxt = S_C1H; go = 1'b1; end
      S_C1H:  if (leave) begin nxt = stage_from(1); go = 1'b1; end
      S_AL:   if (leave) begin nxt = S_AH; go = 1'b1; end
      S_AH:   if (leave) begin
                go = 1'b1;
                if (adr_left > 3'd1) nxt = S_AL;
                else begin
                  nxt = stage_from(2);
                  if (nxt == S_WW) nxt = S_ADL;
                end
              end
      S_ADL:  if (leave) begin nxt = S_WW; go = 1'b1; end
      S_WW:   if (wr_valid) begin nxt = S_WL; go = 1'b1; end
      S_WL:   if (leave) begin nxt = S_WH; go = 1'b1; end
      S_WH:   if (leave) begin
                go  = 1'b1;
                nxt = (wr_left > LEN_W'(1)) ? S_WW : stage_from(3);
              end
      S_C2L:  if (leave) begin nxt = S_C2H; go = 1'b1; end
      S_C2H:  if (leave) begin nxt = stage_from(4); go = 1'b1; end
      S_WB:   if (leave) begin nxt = S_BSY; go = 1'b1; end
      S_BSY:  if (rb_s2) begin
                go  = 1'b1;
                nxt = (rd_left != '0) ? S_RR : S_DONE;
              end else if (bcnt == BSY_W'(BUSY_LIMIT)) begin
                go  = 1'b1;
                nxt = S_DONE;
              end
      S_RR, S_WHR: if (leave) begin nxt = S_RL; go = 1'b1; end
      S_RL:   if (leave) begin nxt = S_RH; go = 1'b1; end
      S_RH:   if (leave && !rd_valid) begin
                go  = 1'b1;
                nxt = (rd_left > LEN_W'(1)) ? S_RL : S_DONE;
              end
      S_DONE: begin nxt = S_IDLE; go = 1'b1; end
      default: begin nxt = S_IDLE; go = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bcnt     <= '0;
      cmd1_q   <= '0;
      cmd2_q   <= '0;
      wbyte_q  <= '0;
      has2_q   <= 1'b0;
      wb_q     <= 1'b0;
      err_q    <= 1'b0;
      rb_s1    <= 1'b1;
      rb_s2    <= 1'b1;
      addr_q   <= '0;
      adr_idx  <= '0;
      adr_left <= '0;
      wr_left  <= '0;
      rd_left  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rb_s1 <= nand_rb_n;
      rb_s2 <= rb_s1;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (go) begin
        state <= nxt;
        cnt   <= CNT_W'(len_of(nxt) - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          cmd1_q  <= req_cmd1;
          cmd2_q  <= req_cmd2;
          has2_q  <= req_has_cmd2;
          wb_q    <= req_wait_busy;
          addr_q  <= req_addr;
          wr_left <= req_wr_len;
          rd_left <= req_rd_len;
          err_q   <= 1'b0;
          adr_idx <= (req_addr_mode == 2'd2) ? 2'd2 : 2'd0;
          case (req_addr_mode)
            2'd1:    adr_left <= 3'd1;
            2'd2:    adr_left <= 3'd2;
            2'd3:    adr_left <= 3'd4;
            default: adr_left <= 3'd0;
          endcase
        end
        S_AH: if (go) begin
          adr_idx  <= adr_idx + 2'd1;
          adr_left <= adr_left - 3'd1;
        end
        S_WW: if (wr_valid) wbyte_q <= wr_data;
        S_WH: if (go) wr_left <= wr_left - 1'b1;
        S_WB: bcnt <= '0;
        S_BSY: if (!rb_s2) begin
          if (bcnt == BSY_W'(BUSY_LIMIT)) err_q <= 1'b1;
          else bcnt <= bcnt + 1'b1;
        end
        S_RL: if (go) begin
          rd_data  <= nand_dq_in;
          rd_valid <= 1'b1;
        end
        S_RH: if (go) rd_left <= rd_left - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (adr_idx)
      2'd0:    abyte = addr_q[7:0];
      2'd1:    abyte = {4'b0000, addr_q[11:8]};
      2'd2:    abyte = addr_q[19:12];
      default: abyte = addr_q[27:20];
    endcase
  end

  always_comb begin
    case (state)
      S_C1L, S_C1H: nand_dq_out = cmd1_q;
      S_AL, S_AH:   nand_dq_out = abyte;
      S_WL, S_WH:   nand_dq_out = wbyte_q;
      S_C2L, S_C2H: nand_dq_out = cmd2_q;
      default:      nand_dq_out = 8'h00;
    endcase
  end

  assign req_ready  = (state == S_IDLE);
  assign wr_ready   = (state == S_WW);
  assign op_done    = (state == S_DONE);
  assign busy_err   = err_q;
  assign nand_ce_n  = (state == S_IDLE);
  assign nand_cle   = state inside {S_C1L, S_C1H, S_C2L, S_C2H};
  assign nand_ale   = state inside {S_AL, S_AH};
  assign nand_we_n  = !(state inside {S_C1L, S_AL, S_WL, S_C2L});
  assign nand_re_n  = (state != S_RL);
  assign nand_dq_oe = state inside {S_C1L, S_C1H, S_AL, S_AH, S_WL, S_WH, S_C2L, S_C2H};

endmodule

// File: rtl/nand_bus_sequencer_chk.sv
module nand_bus_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       op_done,
  input logic       busy_err,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe
);

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nand_we_n && !nand_re_n)); // R11
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (nand_ce_n && nand_we_n && nand_re_n)); // R1
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |-> nand_dq_oe); // R2
  AST_WR_TAKE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && wr_ready) |=> !nand_we_n); // R5
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
  AST_NO_RE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> nand_re_n); // R9
  AST_ERR_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_err) |-> op_done); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) op_done |=> (!op_done && req_ready)); // R12

endmodule

bind nand_bus_sequencer nand_bus_sequencer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .op_done(op_done), .busy_err(busy_err), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe)
);

// File: tb/test_nand_bus_sequencer.sv
module test_nand_bus_sequencer;
  localparam int T_ADL = 5, T_WHR = 3, T_RR = 1, LEN_W = 12;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, req_has_cmd2 = 0, req_wait_busy = 0;
  logic [7:0] req_cmd1 = 0, req_cmd2 = 0, wr_data = 0, rd_data, nand_dq_out, nand_dq_in;
  logic [1:0] req_addr_mode = 0;
  logic [27:0] req_addr = 0;
  logic [LEN_W-1:0] req_wr_len = 0, req_rd_len = 0;
  logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 1, op_done, busy_err;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, rb = 1;

  nand_bus_sequencer #(.T_ADL(T_ADL), .T_WHR(T_WHR), .T_RR(T_RR), .BUSY_LIMIT(1000), .LEN_W(LEN_W)) i_nand_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd1(req_cmd1), .req_cmd2(req_cmd2), .req_has_cmd2(req_has_cmd2),
    .req_addr_mode(req_addr_mode), .req_addr(req_addr), .req_wait_busy(req_wait_busy),
    .req_wr_len(req_wr_len), .req_rd_len(req_rd_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .op_done(op_done), .busy_err(busy_err), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(rb));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int c);
    return 8'(c * 3 + 1);
  endfunction

  logic [7:0] cmd_log[$], addr_log[$], data_log[$], rd_log[$], wr_q[$];
  int last_addr_rise, first_data_rise, last_we_rise, first_re_fall, rb_rise, done_cyc;
  int re_falls, col, busy_delay = 0, busy_left = 0, busy_len = 20, viol = 0, wr_idx = 0;
  bit status_mode = 0, bp = 0, wr_took = 0;
  logic prev_we = 1, prev_re = 1;

  assign nand_dq_in = status_mode ? 8'hE0 : pat(col);

  always @(posedge clk) begin
    if (rd_valid && rd_ready) rd_log.push_back(rd_data);
    if (wr_valid && wr_ready) wr_took = 1;
  end

  always @(negedge clk) begin
    if (!prev_we && nand_we_n) begin
      last_we_rise = cyc;
      if (nand_cle) begin
        cmd_log.push_back(nand_dq_out);
        status_mode = (nand_dq_out == 8'h70);
        if (nand_dq_out == 8'h90) col = 0;
        if (nand_dq_out == 8'h30 && addr_log.size() >= 2)
          col = int'(addr_log[0]) | (int'(addr_log[1]) << 8);
        if (nand_dq_out inside {8'h30, 8'h10, 8'hD0}) busy_delay = 2;
      end else if (nand_ale) begin
        addr_log.push_back(nand_dq_out);
        last_addr_rise = cyc;
      end else begin
        data_log.push_back(nand_dq_out);
        if (first_data_rise < 0) first_data_rise = cyc;
      end
    end
    if (!prev_re && nand_re_n) col++;
    if (prev_re && !nand_re_n) begin
      re_falls++;
      if (first_re_fall < 0) first_re_fall = cyc;
    end
    if (busy_delay > 0) begin
      busy_delay--;
      if (busy_delay == 0) begin rb = 0; busy_left = busy_len; end
    end else if (!rb) begin
      if (busy_left > 0) busy_left--;
      else begin rb = 1; rb_rise = cyc; end
    end
    if (nand_cle && nand_ale) viol++;
    if (!nand_we_n && !nand_re_n) viol++;
    if (nand_ce_n && (!nand_we_n || !nand_re_n)) viol++;
    if (op_done) done_cyc = cyc;
    prev_we = nand_we_n;
    prev_re = nand_re_n;
    if (wr_took) begin wr_idx++; wr_took = 0; end
    wr_valid = (wr_idx < wr_q.size());
    wr_data  = wr_valid ? wr_q[wr_idx] : 8'h00;
    rd_ready = bp ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic run_op(input logic [7:0] c1, input logic [7:0] c2, input bit has2, input logic [1:0] mode,
                        input logic [27:0] a, input bit wbusy, input int nrd);
    cmd_log.delete(); addr_log.delete(); data_log.delete(); rd_log.delete();
    last_addr_rise = -1; first_data_rise = -1; last_we_rise = -1; first_re_fall = -1;
    rb_rise = -1; done_cyc = -1; re_falls = 0; wr_idx = 0;
    @(negedge clk);
    req_cmd1 = c1; req_cmd2 = c2; req_has_cmd2 = has2; req_addr_mode = mode; req_addr = a;
    req_wait_busy = wbusy; req_wr_len = LEN_W'(wr_q.size()); req_rd_len = LEN_W'(nrd);
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready && !nand_ce_n, "R1", "busy while running", {req_ready, nand_ce_n}, 0);
    while (!op_done) @(negedge clk);
    @(negedge clk);
    check(req_ready, "R12", "ready after done", req_ready, 1);
  endtask

  task automatic t_reset;
    check(req_ready && nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
          "R1", "idle outputs", {req_ready, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 6'b111100);
    check(!op_done && !busy_err && !rd_valid, "R12", "no done at reset", {op_done, busy_err, rd_valid}, 0);
  endtask

  task automatic t_status;
    wr_q.delete(); bp = 0;
    run_op(8'h70, 8'h00, 0, 2'd0, 28'h0, 0, 1);
    check(cmd_log.size() == 1 && cmd_log[0] == 8'h70, "R2", "status opcode", cmd_log.size() ? cmd_log[0] : 0, 8'h70);
    check(rd_log.size() == 1 && rd_log[0] == 8'hE0, "R9", "status byte", rd_log.size() ? rd_log[0] : 0, 8'hE0);
    check(first_re_fall - last_we_rise >= T_WHR, "R8", "WE rise to RE fall", first_re_fall - last_we_rise, T_WHR);
    check(addr_log.size() == 0, "R3", "mode 0 no address", addr_log.size(), 0);
  endtask

  task automatic t_read;
    logic [7:0] ea[4] = '{8'h23, 8'h01, 8'hCD, 8'hAB};
    wr_q.delete(); bp = 1; busy_len = 20;
    run_op(8'h00, 8'h30, 1, 2'd3, 28'hABCD123, 1, 5);
    bp = 0;
    check(cmd_log.size() == 2 && cmd_log[0] == 8'h00 && cmd_log[1] == 8'h30, "R2", "read opcodes", cmd_log.size(), 2);
    check(addr_log.size() == 4, "R3", "four address cycles", addr_log.size(), 4);
    foreach (ea[i]) if (i < addr_log.size())
      check(addr_log[i] == ea[i], "R3", $sformatf("address byte %0d", i), addr_log[i], ea[i]);
    check(rb_rise >= 0 && first_re_fall > rb_rise, "R6", "read after ready", first_re_fall, rb_rise);
    check(first_re_fall - rb_rise >= T_RR, "R7", "ready to RE fall", first_re_fall - rb_rise, T_RR);
    check(re_falls == 5 && rd_log.size() == 5, "R9", "read strobes and bytes", re_falls * 16 + rd_log.size(), 16 * 5 + 5);
    foreach (rd_log[i]) check(rd_log[i] == pat(32'h123 + i), "R9", $sformatf("read byte %0d", i), rd_log[i], pat(32'h123 + i));
  endtask

  task automatic t_program;
    wr_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}; bp = 0; busy_len = 30;
    run_op(8'h80, 8'h10, 1, 2'd3, 28'h0040200, 1, 0);
    check(data_log.size() == 6, "R5", "data byte count", data_log.size(), 6);
    foreach (data_log[i]) check(data_log[i] == wr_q[i], "R5", $sformatf("data byte %0d", i), data_log[i], wr_q[i]);
    check(first_data_rise - last_addr_rise >= T_ADL, "R4", "address to data gap", first_data_rise - last_addr_rise, T_ADL);
    check(cmd_log.size() == 2 && cmd_log[1] == 8'h10, "R2", "confirm after data", cmd_log.size() == 2 ? cmd_log[1] : 0, 8'h10);
    check(rb_rise >= 0 && done_cyc > rb_rise, "R6", "done after ready", done_cyc, rb_rise);
    check(re_falls == 0, "R9", "no reads in program", re_falls, 0);
    wr_q.delete();
  endtask

  task automatic t_erase;
    wr_q.delete(); busy_len = 15;
    run_op(8'h60, 8'hD0, 1, 2'd2, 28'h9E42C1F, 1, 0);
    check(addr_log.size() == 2, "R3", "row-only count", addr_log.size(), 2);
    if (addr_log.size() == 2) begin
      check(addr_log[0] == 8'h42, "R3", "row low byte", addr_log[0], 8'h42);
      check(addr_log[1] == 8'h9E, "R3", "row high byte", addr_log[1], 8'h9E);
    end
    check(done_cyc > rb_rise && rb_rise >= 0, "R6", "erase waits ready", done_cyc, rb_rise);
  endtask

  task automatic t_id;
    wr_q.delete();
    run_op(8'h90, 8'h00, 0, 2'd1, 28'hFFFFF00, 0, 2);
    check(addr_log.size() == 1 && addr_log[0] == 8'h00, "R3", "one-byte address", addr_log.size() ? addr_log[0] : 8'hFF, 0);
    check(rd_log.size() == 2 && rd_log[0] == pat(0) && rd_log[1] == pat(1), "R9", "id bytes", rd_log.size(), 2);
    check(first_re_fall - last_we_rise >= T_WHR, "R8", "gap after address", first_re_fall - last_we_rise, T_WHR);
  endtask

  task automatic t_timeout;
    wr_q.delete(); busy_len = 1500;
    run_op(8'h60, 8'hD0, 1, 2'd2, 28'h0001000, 1, 0);
    check(busy_err == 1, "R10", "timeout flag", busy_err, 1);
    check(rb == 0, "R10", "ended while still busy", rb, 0);
    while (!rb) @(negedge clk);
    busy_len = 20;
    @(negedge clk);
    req_cmd1 = 8'h70; req_has_cmd2 = 0; req_addr_mode = 0; req_wait_busy = 0;
    req_wr_len = 0; req_rd_len = 1; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(busy_err == 0, "R10", "flag clears on accept", busy_err, 0);
    while (!op_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    checks++; errors++;
    $display("FAIL R12 watchdog: actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_read();
    t_program();
    t_erase();
    t_id();
    t_timeout();
    check(viol == 0, "R11", "bus exclusivity violations", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule